// File: doc/BRIEF.md
# Half-to-Single Floating-Point Widener

This block takes a 16-bit half-precision value and produces the 32-bit single-precision value it stands for, together with an invalid-operation flag. Every half value fits exactly in single precision, so the path has no rounding: normal values are rebiased, subnormal halves are normalized with a leading-zero count, and the special encodings are decoded according to a format select.

With `alt_fmt` low the input follows the IEEE half layout, where an all-ones exponent means infinity or NaN. With `alt_fmt` high the input uses an alternative half layout that has no infinity or NaN: the all-ones exponent is just the largest normal binade. With `dnan_mode` high any NaN result is replaced by one fixed canonical NaN. The unit is purely combinational and is meant to sit inside a larger datapath stage that registers its result. Internally a classifier sorts the input into one of six classes (zero, subnormal, normal, infinity, quiet NaN, signaling NaN), a leading-zero counter serves the subnormal path, and a packer builds the output for each class.

Top module: `half_to_single_widen`

## Requirements
- R1: A normal half input (exponent 1..30, or 1..31 in alternative format) gives the same sign, exponent plus 112, and the 10-bit fraction placed in bits 22:13 of the 23-bit output fraction with bits 12:0 zero.
- R2: With `alt_fmt` low, an input with exponent 31 and zero fraction gives a single-precision infinity (exponent 255, fraction 0) with the input sign.
- R3: With `alt_fmt` high, exponent 31 is converted as a normal number per R1 whatever its fraction, and `invalid` stays low.
- R4: A zero input (exponent 0, fraction 0) gives a zero of the same sign.
- R5: A subnormal input (exponent 0, fraction nonzero) with L leading zeros in its 10-bit fraction gives exponent 112 - L and the fraction shifted left by L+1, keeping the low 10 bits, placed in bits 22:13.
- R6: With `alt_fmt` low and `dnan_mode` low, a signaling NaN (exponent 31, fraction bit 9 clear, fraction nonzero) raises `invalid` and gives exponent 255, the input sign, and the fraction placed per R1 with output fraction bit 22 set.
- R7: With `alt_fmt` low and `dnan_mode` high, any NaN input gives 0x7FC00000; `invalid` is high only when the input was signaling.
- R8: With `alt_fmt` low and `dnan_mode` low, a quiet NaN (exponent 31, fraction bit 9 set) keeps its sign and its fraction placed per R1, with exponent 255 and `invalid` low.
- R9: `invalid` is low for every input that is not a signaling NaN under the IEEE layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| half_in | input | 16 | Half-precision operand: bit 15 sign, bits 14:10 exponent, bits 9:0 fraction |
| alt_fmt | input | 1 | 1 selects the alternative layout without infinity or NaN |
| dnan_mode | input | 1 | 1 replaces every NaN result with the canonical NaN |
| single_out | output | 32 | Single-precision result: bit 31 sign, bits 30:23 exponent, bits 22:0 fraction |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default widths of a 5-bit half exponent with 10-bit fraction and an 8-bit single exponent with 23-bit fraction. These values put the smallest and largest subnormal shifts, both edge binades of the normal range, the exponent-31 encoding under both layouts, and both NaN kinds with and without default-NaN mode within reach of a handful of directed vectors whose exact single-precision patterns are known beforehand.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fcls_e;
endpackage

// File: rtl/fpw_classify.sv
module fpw_classify
    import fpw_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W-1:0] exp_in,
    input  logic [MAN_W-1:0] man_in,
    input  logic             alt_fmt,
    output fcls_e            cls
);
    logic exp_ones;
    logic exp_none;
    logic man_none;

    always_comb begin
        exp_ones = &exp_in;
        exp_none = ~|exp_in;
        man_none = ~|man_in;
        if (exp_none) begin
            cls = man_none ? CLS_ZERO : CLS_SUB;
        end else if (exp_ones && !alt_fmt) begin
            if (man_none) begin
                cls = CLS_INF;
            end else if (man_in[MAN_W-1]) begin
                cls = CLS_QNAN;
            end else begin
                cls = CLS_SNAN;
            end
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/fpw_pack.sv
module fpw_pack
    import fpw_pkg::*;
#(
    parameter int HEXP_W = 5,
    parameter int HMAN_W = 10,
    parameter int SEXP_W = 8,
    parameter int SMAN_W = 23,
    parameter int CW     = $clog2(HMAN_W + 1)
) (
    input  fcls_e                    cls,
    input  logic                     sign_in,
    input  logic [HEXP_W-1:0]        exp_in,
    input  logic [HMAN_W-1:0]        man_in,
    input  logic [CW-1:0]            lz,
    input  logic                     dnan_mode,
    output logic [SEXP_W+SMAN_W:0]   result,
    output logic                     invalid
);
    localparam int HBIAS      = (2 ** (HEXP_W - 1)) - 1;
    localparam int SBIAS      = (2 ** (SEXP_W - 1)) - 1;
    localparam int BIAS_DELTA = SBIAS - HBIAS;
    localparam int PAD        = SMAN_W - HMAN_W;
    localparam logic [SEXP_W-1:0] EXP_ONES = '1;
    localparam logic [SMAN_W-1:0] QUIET_BIT = SMAN_W'(1) << (SMAN_W - 1);

    logic              r_sign;
    logic [SEXP_W-1:0] r_exp;
    logic [SMAN_W-1:0] r_man;
    logic [HMAN_W-1:0] sub_man;
    logic [SMAN_W-1:0] wide_man;

    always_comb begin
        sub_man  = man_in << (lz + CW'(1));
        wide_man = {man_in, {PAD{1'b0}}};
        r_sign   = sign_in;
        r_exp    = '0;
        r_man    = '0;
        invalid  = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                r_exp = '0;
            end
            CLS_SUB: begin
                r_exp = SEXP_W'(BIAS_DELTA) - SEXP_W'(lz);
                r_man = {sub_man, {PAD{1'b0}}};
            end
            CLS_NORM: begin
                r_exp = SEXP_W'(BIAS_DELTA) + SEXP_W'(exp_in);
                r_man = wide_man;
            end
            CLS_INF: begin
                r_exp = EXP_ONES;
            end
            CLS_QNAN, CLS_SNAN: begin
                invalid = (cls == CLS_SNAN);
                r_exp   = EXP_ONES;
                if (dnan_mode) begin
                    r_sign = 1'b0;
                    r_man  = QUIET_BIT;
                end else begin
                    r_man  = wide_man | QUIET_BIT;
                end
            end
            default: begin
                r_exp = '0;
            end
        endcase
        result = {r_sign, r_exp, r_man};
    end
endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
    import fpw_pkg::*;
#(
    parameter int HALF_EXP_W = 5,
    parameter int HALF_MAN_W = 10,
    parameter int SGL_EXP_W  = 8,
    parameter int SGL_MAN_W  = 23
) (
    input  logic [HALF_EXP_W+HALF_MAN_W:0] half_in,
    input  logic                           alt_fmt,
    input  logic                           dnan_mode,
    output logic [SGL_EXP_W+SGL_MAN_W:0]   single_out,
    output logic                           invalid
);
    localparam int HALF_W = HALF_EXP_W + HALF_MAN_W + 1;
    localparam int LZ_W   = $clog2(HALF_MAN_W + 1);

    logic                  h_sign;
    logic [HALF_EXP_W-1:0] h_exp;
    logic [HALF_MAN_W-1:0] h_man;
    logic [LZ_W-1:0]       h_lz;
    fcls_e                 h_cls;

    assign h_sign = half_in[HALF_W-1];
    assign h_exp  = half_in[HALF_W-2:HALF_MAN_W];
    assign h_man  = half_in[HALF_MAN_W-1:0];

    fpw_classify #(
        .EXP_W(HALF_EXP_W),
        .MAN_W(HALF_MAN_W)
    ) u_classify (
        .exp_in (h_exp),
        .man_in (h_man),
        .alt_fmt(alt_fmt),
        .cls    (h_cls)
    );

    fpw_lzc #(
        .W (HALF_MAN_W),
        .CW(LZ_W)
    ) u_lzc (
        .vec(h_man),
        .cnt(h_lz)
    );

    fpw_pack #(
        .HEXP_W(HALF_EXP_W),
        .HMAN_W(HALF_MAN_W),
        .SEXP_W(SGL_EXP_W),
        .SMAN_W(SGL_MAN_W),
        .CW    (LZ_W)
    ) u_pack (
        .cls      (h_cls),
        .sign_in  (h_sign),
        .exp_in   (h_exp),
        .man_in   (h_man),
        .lz       (h_lz),
        .dnan_mode(dnan_mode),
        .result   (single_out),
        .invalid  (invalid)
    );
endmodule

// File: rtl/half_to_single_widen_chk.sv
module half_to_single_widen_chk #(
    parameter int HALF_EXP_W = 5,
    parameter int HALF_MAN_W = 10,
    parameter int SGL_EXP_W  = 8,
    parameter int SGL_MAN_W  = 23
) (
    input logic [HALF_EXP_W+HALF_MAN_W:0] half_in,
    input logic                           alt_fmt,
    input logic                           dnan_mode,
    input logic [SGL_EXP_W+SGL_MAN_W:0]   single_out,
    input logic                           invalid
);
    localparam int HW = HALF_EXP_W + HALF_MAN_W + 1;
    localparam int SW = SGL_EXP_W + SGL_MAN_W + 1;

    logic                  s_in;
    logic                  e_ones;
    logic                  m_zero;
    logic                  m_top;
    logic [SGL_EXP_W-1:0]  o_exp;

    always_comb begin
        s_in   = half_in[HW-1];
        e_ones = &half_in[HW-2:HALF_MAN_W];
        m_zero = ~|half_in[HALF_MAN_W-1:0];
        m_top  = half_in[HALF_MAN_W-1];
        o_exp  = single_out[SW-2:SGL_MAN_W];
        if (!$isunknown({half_in, alt_fmt, dnan_mode})) begin
            p_flag_snan_r9: assert (invalid == (!alt_fmt && e_ones && !m_zero && !m_top))
                else $error("invalid flag disagrees with input class");
            p_inf_ieee_r2: assert (!( !alt_fmt && e_ones && m_zero) ||
                                   single_out == {s_in, {SGL_EXP_W{1'b1}}, {SGL_MAN_W{1'b0}}})
                else $error("infinity not produced");
            p_alt_finite_r3: assert (!alt_fmt || (o_exp != {SGL_EXP_W{1'b1}} && !invalid))
                else $error("alternative layout produced a special value");
            p_signed_zero_r4: assert (!(half_in[HW-2:0] == '0) ||
                                      single_out == {s_in, {(SW-1){1'b0}}})
                else $error("zero not preserved");
            p_default_nan_r7: assert (!( !alt_fmt && e_ones && !m_zero && dnan_mode) ||
                                      single_out == {1'b0, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_MAN_W-1){1'b0}}})
                else $error("default NaN not produced");
            p_snan_quieted_r6: assert (!invalid || (o_exp == {SGL_EXP_W{1'b1}} && single_out[SGL_MAN_W-1]))
                else $error("flagged result is not a quiet NaN");
        end
    end
endmodule

bind half_to_single_widen half_to_single_widen_chk #(
    .HALF_EXP_W(HALF_EXP_W),
    .HALF_MAN_W(HALF_MAN_W),
    .SGL_EXP_W (SGL_EXP_W),
    .SGL_MAN_W (SGL_MAN_W)
) u_chk (
    .half_in   (half_in),
    .alt_fmt   (alt_fmt),
    .dnan_mode (dnan_mode),
    .single_out(single_out),
    .invalid   (invalid)
);

// File: tb/half_to_single_widen_tb.sv
`timescale 1ns/1ps
module half_to_single_widen_tb;
    logic        clk;
    logic        rst_n;
    logic [15:0] half_in;
    logic        alt_fmt;
    logic        dnan_mode;
    logic [31:0] single_out;
    logic        invalid;

    int n_checks;
    int n_fails;
    bit done;

    half_to_single_widen u_dut (
        .half_in   (half_in),
        .alt_fmt   (alt_fmt),
        .dnan_mode (dnan_mode),
        .single_out(single_out),
        .invalid   (invalid)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic apply_check(input string req, input logic [15:0] h, input logic alt,
                               input logic dn, input logic [31:0] exp_out, input logic exp_inv);
        @(negedge clk);
        half_in   = h;
        alt_fmt   = alt;
        dnan_mode = dn;
        @(posedge clk);
        #2;
        n_checks++;
        if (single_out !== exp_out || invalid !== exp_inv) begin
            n_fails++;
            $display("FAIL %s: in=%h alt=%0b dn=%0b actual=%h/%0b expected=%h/%0b",
                     req, h, alt, dn, single_out, invalid, exp_out, exp_inv);
        end
    endtask

    task automatic t_reset_state();
        apply_check("R4", 16'h0000, 1'b0, 1'b0, 32'h00000000, 1'b0);
    endtask

    task automatic t_normals();
        apply_check("R1", 16'h3C00, 1'b0, 1'b0, 32'h3F800000, 1'b0);
        apply_check("R1", 16'hC000, 1'b0, 1'b0, 32'hC0000000, 1'b0);
        apply_check("R1", 16'h7BFF, 1'b0, 1'b0, 32'h477FE000, 1'b0);
        apply_check("R1", 16'h0400, 1'b0, 1'b1, 32'h38800000, 1'b0);
    endtask

    task automatic t_infinity();
        apply_check("R2", 16'h7C00, 1'b0, 1'b0, 32'h7F800000, 1'b0);
        apply_check("R2", 16'hFC00, 1'b0, 1'b1, 32'hFF800000, 1'b0);
    endtask

    task automatic t_alt_layout();
        apply_check("R3", 16'h7C00, 1'b1, 1'b0, 32'h47800000, 1'b0);
        apply_check("R3", 16'h7FFF, 1'b1, 1'b1, 32'h47FFE000, 1'b0);
        apply_check("R3", 16'hFE00, 1'b1, 1'b0, 32'hC7C00000, 1'b0);
        apply_check("R3", 16'h7C01, 1'b1, 1'b0, 32'h47802000, 1'b0);
        apply_check("R3", 16'h3C00, 1'b1, 1'b0, 32'h3F800000, 1'b0);
    endtask

    task automatic t_zeros();
        apply_check("R4", 16'h8000, 1'b0, 1'b0, 32'h80000000, 1'b0);
        apply_check("R4", 16'h8000, 1'b1, 1'b1, 32'h80000000, 1'b0);
    endtask

    task automatic t_subnormals();
        apply_check("R5", 16'h0001, 1'b0, 1'b0, 32'h33800000, 1'b0);
        apply_check("R5", 16'h0200, 1'b0, 1'b0, 32'h38000000, 1'b0);
        apply_check("R5", 16'h03FF, 1'b0, 1'b0, 32'h387FC000, 1'b0);
        apply_check("R5", 16'h8001, 1'b1, 1'b0, 32'hB3800000, 1'b0);
    endtask

    task automatic t_signaling();
        apply_check("R6", 16'h7C01, 1'b0, 1'b0, 32'h7FC02000, 1'b1);
        apply_check("R6", 16'hFD55, 1'b0, 1'b0, 32'hFFEAA000, 1'b1);
    endtask

    task automatic t_default_nan();
        apply_check("R7", 16'h7C01, 1'b0, 1'b1, 32'h7FC00000, 1'b1);
        apply_check("R7", 16'hFE00, 1'b0, 1'b1, 32'h7FC00000, 1'b0);
    endtask

    task automatic t_quiet();
        apply_check("R8", 16'h7E00, 1'b0, 1'b0, 32'h7FC00000, 1'b0);
        apply_check("R8", 16'hFF01, 1'b0, 1'b0, 32'hFFE02000, 1'b0);
    endtask

    task automatic t_no_flag();
        apply_check("R9", 16'h0155, 1'b0, 1'b1, 32'h37AA8000, 1'b0);
        apply_check("R9", 16'hFBFF, 1'b1, 1'b1, 32'hC77FE000, 1'b0);
    endtask

    initial begin
        n_checks  = 0;
        n_fails   = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        half_in   = 16'h0000;
        alt_fmt   = 1'b0;
        dnan_mode = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_normals();
        t_infinity();
        t_alt_layout();
        t_zeros();
        t_subnormals();
        t_signaling();
        t_default_nan();
        t_quiet();
        t_no_flag();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule